// File: doc/BRIEF.md
# Mode-Configurable PLD Output Macrocell Array

This block is the output stage of a small sum-of-products programmable logic device. It holds eight macrocells. Each cell receives eight product terms from an AND-array outside the block. It produces a pad value, a pad drive enable and a feedback bit that returns to the array. A two-bit global mode picks one of three arrangements: registered, complex or simple. Per-cell bits choose registered or combinatorial operation, input-only use, and output polarity.

Two dedicated pins change role with the mode. The clock-or-input pin `cpin` acts as the common register clock in registered mode. In that mode it is sampled by the system clock, and the cell flip-flops load on its rising transition. In complex mode it feeds the array through the feedback slot of cell 0, and in simple mode it is a plain array input. The enable-or-input pin `epin` follows the same pattern. It is the active-low common output enable in registered mode, it takes the feedback slot of cell 7 in complex mode, and it is a plain input in simple mode. Every output is held in a register, so each output reflects the inputs sampled at the previous system clock edge.

Cell c drives device pin 19-c. Product term bits `pterm[8c+7:8c]` belong to cell c. Bit `8c+7` of that field is the cell's enable term whenever a cell splits its terms between the sum and the enable.

Top module: `pld_mc_array`

## Requirements
- R1: One edge with `rst` high clears `pad_out`, `pad_oe`, `arr_fb` and `arr_side` to zero and clears every cell flip-flop, so the first output of a registered cell after reset is 1.
- R2: Every output changes only at a rising edge of `clk` and shows the inputs sampled at that edge. A change between edges is not visible until the next edge.
- R3: In registered mode (`mode_sel`=2'b10), a cell with `cfg_reg`=1 and `cfg_inp`=0 loads the OR of all eight of its terms at a `clk` edge where `cpin` is 1 and was 0 at the previous edge. Its `pad_out` is the inverted flip-flop, its `arr_fb` is the flip-flop itself, and its `pad_oe` is the inverse of `epin`.
- R4: In registered mode, a cell with `cfg_reg`=0 and `cfg_inp`=0 drives the OR of terms 0..6 XOR `cfg_inv`, is enabled by term 7, and feeds back its own `pad_in`. In this mode `arr_side` is 0.
- R5: In registered mode a cell with `cfg_inp`=1 has `pad_oe`=0 and `pad_out`=0 and feeds back its own `pad_in`.
- R6: In complex mode (2'b01), every cell drives the OR of terms 0..6 XOR `cfg_inv` and is enabled by term 7. `cfg_reg` and `cfg_inp` are ignored. `arr_fb[0]` carries `cpin`, `arr_fb[7]` carries `epin`, cells 1..6 feed back their own `pad_in`, and `arr_side` is 0.
- R7: In simple mode (2'b00), a cell drives the OR of all eight terms XOR `cfg_inv` and ignores `cfg_reg`. A cell with `cfg_inp`=1 that is not a centre cell has `pad_oe`=0 and `pad_out`=0. Cells 0..2 feed back `pad_in` of the next higher cell, cells 5..7 feed back `pad_in` of the next lower cell, and `arr_side` is {`epin`,`cpin`}.
- R8: In simple mode the centre cells 3 and 4 are always enabled, ignore `cfg_inp`, and feed back 0.
- R9: The encoding 2'b11 behaves exactly as simple mode.
- R10: A cell flip-flop holds its value when no rising transition of `cpin` occurs, when `cpin` stays high, and while the mode is not registered. It keeps that value across a mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Global mode: 00 simple, 01 complex, 10 registered, 11 simple |
| cfg_reg | input | 8 | Per-cell registered select (registered mode) |
| cfg_inp | input | 8 | Per-cell input-only select |
| cfg_inv | input | 8 | Per-cell inversion of combinatorial outputs |
| pterm | input | 64 | Product terms, eight per cell |
| cpin | input | 1 | Clock-or-input pin (device pin 1) |
| epin | input | 1 | Enable-or-input pin (device pin 11), active low as enable |
| pad_in | input | 8 | Sensed pad values of the cells |
| pad_out | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad drive enables |
| arr_fb | output | 8 | Feedback bits to the AND-array |
| arr_side | output | 2 | Dedicated-pin array inputs {epin, cpin} in simple mode |

## Verification
A rising transition on the clock pin can arrive in the same sampled cycle as a mode change or as a change on the enable pin. The bench provokes both cases. It raises `cpin` in the very cycle that leaves registered mode, returns to registered mode with the pin still high, and expects the flip-flops to be unchanged. It also raises `cpin` together with `epin` and expects the new register contents and the disabled drivers to appear together one edge later. A later excursion through complex mode must leave the loaded flip-flops intact.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

  typedef enum logic [1:0] {
    MODE_SIMPLE  = 2'b00,
    MODE_COMPLEX = 2'b01,
    MODE_REGD    = 2'b10,
    MODE_ALIAS   = 2'b11
  } mc_mode_e;

  typedef struct packed {
    logic regd;
    logic cplx;
    logic smpl;
  } mode_dec_t;

endpackage

// File: rtl/pld_mode_decode.sv
module pld_mode_decode
  import pld_mc_pkg::*;
(
  input  logic [1:0] mode_sel,
  output mode_dec_t  dec
);

  mc_mode_e m;

  always_comb begin
    m   = mc_mode_e'(mode_sel);
    dec = '0;
    unique case (m)
      MODE_REGD:    dec.regd = 1'b1;
      MODE_COMPLEX: dec.cplx = 1'b1;
      default:      dec.smpl = 1'b1;
    endcase
  end

endmodule

// File: rtl/pld_clkpin_edge.sv
module pld_clkpin_edge (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);

  logic pin_q;

  // reset to 1 so a pin already high at reset release is not taken as an edge
  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b1;
    else     pin_q <= pin;
  end

  assign rise = pin & ~pin_q;

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import pld_mc_pkg::*;
#(
  parameter int NPT       = 8,
  parameter bit IS_CENTER = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  mode_dec_t      dec,
  input  logic           clk_rise,
  input  logic           cfg_reg,
  input  logic           cfg_inp,
  input  logic           cfg_inv,
  input  logic [NPT-1:0] pt,
  input  logic           oe_pin_n,
  input  logic           pad_self,
  input  logic           fb_cplx,
  input  logic           fb_smpl,
  output logic           out_nxt,
  output logic           oe_nxt,
  output logic           fb_nxt
);

  localparam int SUM_LO_W = NPT - 1;

  logic sum_all, sum_lo, pt_oe;
  logic mq, mq_nxt, load;

  assign sum_all = |pt;
  assign sum_lo  = |pt[SUM_LO_W-1:0];
  assign pt_oe   = pt[NPT-1];

  assign load   = dec.regd & cfg_reg & ~cfg_inp & clk_rise;
  assign mq_nxt = load ? sum_all : mq;

  always_ff @(posedge clk) begin
    if (rst) mq <= 1'b0;
    else     mq <= mq_nxt;
  end

  always_comb begin
    out_nxt = 1'b0;
    oe_nxt  = 1'b0;
    fb_nxt  = 1'b0;
    if (dec.regd) begin
      if (cfg_inp) begin
        fb_nxt = pad_self;
      end else if (cfg_reg) begin
        out_nxt = ~mq_nxt;
        oe_nxt  = ~oe_pin_n;
        fb_nxt  = mq_nxt;
      end else begin
        out_nxt = sum_lo ^ cfg_inv;
        oe_nxt  = pt_oe;
        fb_nxt  = pad_self;
      end
    end else if (dec.cplx) begin
      out_nxt = sum_lo ^ cfg_inv;
      oe_nxt  = pt_oe;
      fb_nxt  = fb_cplx;
    end else begin
      if (IS_CENTER) begin
        out_nxt = sum_all ^ cfg_inv;
        oe_nxt  = 1'b1;
        fb_nxt  = 1'b0;
      end else if (cfg_inp) begin
        fb_nxt = fb_smpl;
      end else begin
        out_nxt = sum_all ^ cfg_inv;
        oe_nxt  = 1'b1;
        fb_nxt  = fb_smpl;
      end
    end
  end

endmodule

// File: rtl/pld_mc_array.sv
module pld_mc_array
  import pld_mc_pkg::*;
#(
  parameter int NCELL = 8,
  parameter int NPT   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode_sel,
  input  logic [NCELL-1:0]   cfg_reg,
  input  logic [NCELL-1:0]   cfg_inp,
  input  logic [NCELL-1:0]   cfg_inv,
  input  logic [NCELL*NPT-1:0] pterm,
  input  logic               cpin,
  input  logic               epin,
  input  logic [NCELL-1:0]   pad_in,
  output logic [NCELL-1:0]   pad_out,
  output logic [NCELL-1:0]   pad_oe,
  output logic [NCELL-1:0]   arr_fb,
  output logic [1:0]         arr_side
);

  localparam int CTR_LO = NCELL/2 - 1;
  localparam int CTR_HI = NCELL/2;
  localparam int LAST   = NCELL - 1;

  mode_dec_t        dec;
  logic             clk_rise;
  logic [NCELL-1:0] out_nxt, oe_nxt, fb_nxt;
  logic [NCELL-1:0] fb_cplx, fb_smpl;
  logic [1:0]       side_nxt;

  pld_mode_decode u_dec (
    .mode_sel (mode_sel),
    .dec      (dec)
  );

  pld_clkpin_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .pin  (cpin),
    .rise (clk_rise)
  );

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    // complex-mode feedback: outer cells give their slot to the dedicated pins
    if (c == 0) begin : g_cx_first
      assign fb_cplx[c] = cpin;
    end else if (c == LAST) begin : g_cx_last
      assign fb_cplx[c] = epin;
    end else begin : g_cx_mid
      assign fb_cplx[c] = pad_in[c];
    end

    // simple-mode feedback: taken from the neighbour towards the centre
    if (c < CTR_LO) begin : g_sm_low
      assign fb_smpl[c] = pad_in[c+1];
    end else if (c > CTR_HI) begin : g_sm_high
      assign fb_smpl[c] = pad_in[c-1];
    end else begin : g_sm_ctr
      assign fb_smpl[c] = 1'b0;
    end

    pld_macrocell #(
      .NPT       (NPT),
      .IS_CENTER ((c == CTR_LO) || (c == CTR_HI))
    ) u_mc (
      .clk      (clk),
      .rst      (rst),
      .dec      (dec),
      .clk_rise (clk_rise),
      .cfg_reg  (cfg_reg[c]),
      .cfg_inp  (cfg_inp[c]),
      .cfg_inv  (cfg_inv[c]),
      .pt       (pterm[c*NPT +: NPT]),
      .oe_pin_n (epin),
      .pad_self (pad_in[c]),
      .fb_cplx  (fb_cplx[c]),
      .fb_smpl  (fb_smpl[c]),
      .out_nxt  (out_nxt[c]),
      .oe_nxt   (oe_nxt[c]),
      .fb_nxt   (fb_nxt[c])
    );
  end

  assign side_nxt = dec.smpl ? {epin, cpin} : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out  <= '0;
      pad_oe   <= '0;
      arr_fb   <= '0;
      arr_side <= '0;
    end else begin
      pad_out  <= out_nxt;
      pad_oe   <= oe_nxt;
      arr_fb   <= fb_nxt;
      arr_side <= side_nxt;
    end
  end

endmodule

// File: rtl/pld_mc_array_chk.sv
module pld_mc_array_chk #(
  parameter int NCELL = 8,
  parameter int NPT   = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           mode_sel,
  input logic [NCELL-1:0]     cfg_reg,
  input logic [NCELL-1:0]     cfg_inp,
  input logic [NCELL-1:0]     cfg_inv,
  input logic [NCELL*NPT-1:0] pterm,
  input logic                 cpin,
  input logic                 epin,
  input logic [NCELL-1:0]     pad_in,
  input logic [NCELL-1:0]     pad_out,
  input logic [NCELL-1:0]     pad_oe,
  input logic [NCELL-1:0]     arr_fb,
  input logic [1:0]           arr_side
);

  localparam int CTR_LO = NCELL/2 - 1;
  localparam int CTR_HI = NCELL/2;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pad_out == '0 && pad_oe == '0 && arr_fb == '0 && arr_side == 2'b00));

  // R4
  regd_side_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b10) |=> (arr_side == 2'b00));

  // R6
  cplx_route_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b01) |=> (arr_fb[0] == $past(cpin) && arr_fb[NCELL-1] == $past(epin)
                             && arr_side == 2'b00));

  // R8
  center_on_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel[0] == mode_sel[1]) |=> (pad_oe[CTR_LO] && pad_oe[CTR_HI]
                                      && !arr_fb[CTR_LO] && !arr_fb[CTR_HI]));

  // R9
  alias_side_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b11) |=> (arr_side == $past({epin, cpin})));

  for (genvar c = 0; c < NCELL; c++) begin : g_cell_chk
    // R3
    regd_enable_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_sel == 2'b10 && cfg_reg[c] && !cfg_inp[c]) |=> (pad_oe[c] == !$past(epin)));

    // R5
    input_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_sel == 2'b10 && cfg_inp[c]) |=> (!pad_oe[c] && !pad_out[c]
                                             && arr_fb[c] == $past(pad_in[c])));

    // R10
    hold_no_edge_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_sel == 2'b10 && $past(mode_sel) == 2'b10 && cfg_reg[c] && $past(cfg_reg[c])
       && !cfg_inp[c] && !$past(cfg_inp[c]) && !cpin) |=> (arr_fb[c] == $past(arr_fb[c])));
  end

endmodule

bind pld_mc_array pld_mc_array_chk #(.NCELL(NCELL), .NPT(NPT)) u_chk (.*);

// File: tb/pld_mc_array_test.sv
module pld_mc_array_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_sel = 2'b00;
  logic [7:0]  cfg_reg = '0, cfg_inp = '0, cfg_inv = '0;
  logic [63:0] pterm = '0;
  logic        cpin = 1'b0, epin = 1'b0;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_out, pad_oe, arr_fb;
  logic [1:0]  arr_side;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pld_mc_array uut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .cfg_reg(cfg_reg), .cfg_inp(cfg_inp),
    .cfg_inv(cfg_inv), .pterm(pterm), .cpin(cpin), .epin(epin), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .arr_fb(arr_fb), .arr_side(arr_side)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic do_reset();
    rst = 1'b1; mode_sel = 2'b00; cfg_reg = '0; cfg_inp = '0; cfg_inv = '0;
    pterm = '0; cpin = 1'b0; epin = 1'b0; pad_in = '0;
    step();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; mode_sel = 2'b10; cfg_reg = 8'hFF; pterm = '1; pad_in = 8'hFF; cpin = 1'b1;
    step();
    chk("R1 pad_out in reset", pad_out, 8'h00);
    chk("R1 pad_oe in reset", pad_oe, 8'h00);
    chk("R1 arr_fb in reset", arr_fb, 8'h00);
    chk("R1 arr_side in reset", {6'd0, arr_side}, 8'h00);
  endtask

  task automatic t_registered();
    do_reset();
    mode_sel = 2'b10; cfg_reg = 8'hFF;
    step();
    chk("R1 first registered output high", pad_out, 8'hFF);
    chk("R3 enable follows low epin", pad_oe, 8'hFF);
    chk("R1 flops clear", arr_fb, 8'h00);
    for (int c = 1; c < 8; c += 2) pterm[c*8 + c] = 1'b1;
    step();
    chk("R10 no clock-pin edge no load", arr_fb, 8'h00);
    cpin = 1'b1;
    step();
    chk("R3 flop value on feedback", arr_fb, 8'hAA);
    chk("R3 inverted flop on pad", pad_out, 8'h55);
    pterm = '0;
    step();
    chk("R10 pin held high no reload", arr_fb, 8'hAA);
    epin = 1'b1;
    step();
    chk("R3 epin high disables", pad_oe, 8'h00);
    chk("R3 value kept while disabled", pad_out, 8'h55);
    cpin = 1'b0;
    step();
    cpin = 1'b1;
    step();
    chk("R3 reload zeros", arr_fb, 8'h00);
    chk("R3 reload pad", pad_out, 8'hFF);
  endtask

  task automatic t_reg_mix();
    do_reset();
    mode_sel = 2'b10; cfg_reg = 8'h0F; cfg_inp = 8'h30; cfg_inv = 8'h90; pad_in = 8'hC3;
    pterm[39] = 1'b1;
    pterm[48] = 1'b1; pterm[55] = 1'b1;
    pterm[63] = 1'b1;
    step();
    chk("R4 R5 enables", pad_oe, 8'hCF);
    chk("R4 R5 pad values", pad_out, 8'hCF);
    chk("R4 R5 feedback", arr_fb, 8'hC0);
    chk("R4 side inputs zero", {6'd0, arr_side}, 8'h00);
  endtask

  task automatic t_complex();
    do_reset();
    mode_sel = 2'b01; cfg_reg = 8'hFF; cfg_inp = 8'hFF; cfg_inv = 8'h08;
    cpin = 1'b1; epin = 1'b0; pad_in = 8'h81;
    pterm[7] = 1'b1; pterm[8] = 1'b1; pterm[22] = 1'b1; pterm[23] = 1'b1;
    step();
    chk("R6 pad values", pad_out, 8'h0E);
    chk("R6 term-7 enables", pad_oe, 8'h05);
    chk("R6 outer feedback from dedicated pins", arr_fb, 8'h01);
    chk("R6 side inputs zero", {6'd0, arr_side}, 8'h00);
  endtask

  task automatic t_simple(logic [1:0] m, string tag);
    do_reset();
    mode_sel = m; cfg_inp = 8'h89; cfg_reg = 8'hFF; cfg_inv = 8'h10; pad_in = 8'hA6;
    cpin = 1'b1; epin = 1'b0;
    pterm[0] = 1'b1; pterm[15] = 1'b1; pterm[26] = 1'b1;
    step();
    chk({tag, " R7 pad values"}, pad_out, 8'h1A);
    chk({tag, " R7 R8 enables"}, pad_oe, 8'h7E);
    chk({tag, " R7 R8 neighbour feedback"}, arr_fb, 8'h43);
    chk({tag, " R7 side inputs"}, {6'd0, arr_side}, 8'h01);
    pad_in = 8'h00;
    #1;
    chk({tag, " R2 no change before edge"}, arr_fb, 8'h43);
    step();
    chk({tag, " R2 change after edge"}, arr_fb, 8'h00);
  endtask

  task automatic t_coincide();
    do_reset();
    mode_sel = 2'b10; cfg_reg = 8'hFF; pterm = '1;
    step();
    chk("R1 registered high before load", pad_out, 8'hFF);
    mode_sel = 2'b01; cpin = 1'b1;
    step();
    chk("R6 edge during complex mode", arr_fb, 8'h01);
    mode_sel = 2'b10;
    step();
    chk("R10 no load on mode switch edge", arr_fb, 8'h00);
    chk("R10 pad unchanged", pad_out, 8'hFF);
    cpin = 1'b0;
    step();
    cpin = 1'b1; epin = 1'b1;
    step();
    chk("R3 load with enable change", arr_fb, 8'hFF);
    chk("R3 pad after load", pad_out, 8'h00);
    chk("R3 disabled same cycle", pad_oe, 8'h00);
    mode_sel = 2'b01;
    step();
    mode_sel = 2'b10;
    step();
    chk("R10 value kept across complex mode", arr_fb, 8'hFF);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_registered();
    t_reg_mix();
    t_complex();
    t_simple(2'b00, "simple");
    t_simple(2'b11, "R9 alias");
    t_coincide();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

endmodule